// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block is the last stage of a broadcast channel receiver. It takes 188-byte transport packets, one byte per handshake, from an upstream error-correction stage. It presents them on an output port together with a generated output clock, a data-valid strobe, a packet-start pulse and a per-packet uncorrectable-error flag. The upstream side offers a byte, a start-of-packet qualifier, a valid qualifier and an uncorrectable qualifier. The formatter answers with a ready signal, so the upstream stage is paced by the output rate.

Two static configuration fields choose the port format and the clock edge. In byte-wide mode one byte leaves on every output clock. In bit-serial mode each byte is shifted out on the lowest data pin, most significant bit first, over eight output clocks. The output clock runs at half the system clock. All outputs change together on one chosen edge of it, so a receiver can capture them on the opposite edge. The formatter holds at most one byte in flight. A packet is framed only by the upstream start-of-packet marker. Bytes that arrive outside a packet are taken and dropped.

Top module: `ts_out_fmt`

## Requirements
- R1: While reset is asserted, ts_data, ts_valid, ts_sync, ts_err and in_ready are all 0, and ts_clk is 0 when cfg_clk_inv is 0.
- R2: ts_clk toggles on every system clock cycle. ts_data, ts_valid, ts_sync and ts_err change only on the ts_clk edge that goes to the level equal to cfg_clk_inv: the falling edge by default, the rising edge when cfg_clk_inv is 1. They are stable at the opposite edge.
- R3: With cfg_serial = 0, each accepted packet byte appears on ts_data[7:0] for exactly one output clock period, in acceptance order.
- R4: With cfg_serial = 1, each packet byte occupies eight consecutive output clock periods on ts_data[0], bit 7 first and bit 0 last. ts_data[7:1] is 0 throughout.
- R5: ts_sync is 1 exactly while the first byte of a packet is presented: one period in byte-wide mode, all eight bit periods in serial mode. ts_sync is 1 only when ts_valid is 1.
- R6: ts_valid is 1 only while a packet byte (or one of its bits) is presented. It is 0 in every output period where no new byte was available.
- R7: ts_err equals in_uncor as sampled with the start-of-packet byte, for every presented byte of that packet and during stalls inside it. in_uncor on other bytes is ignored. ts_err is 0 once a packet has finished and no new one has begun.
- R8: When upstream stalls inside a packet, ts_clk keeps toggling, ts_valid drops, and the packet byte position holds, so the packet still ends after exactly 188 presented bytes.
- R9: A byte with in_sop = 0 that arrives before any packet, or after the 188th byte of a packet, is still accepted but produces no output (ts_valid stays 0).
- R10: A byte with in_sop = 1 that arrives before the current packet has 188 bytes ends that packet at once and starts a new 188-byte packet with this byte as its first byte.
- R11: A byte is accepted in a cycle where in_valid and in_ready are both 1. in_ready is 1 only in the system cycle before an output update edge, and in serial mode only once all eight bits of the previous byte have been scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_serial | input | 1 | 1 selects bit-serial output on ts_data[0], 0 selects byte-wide output |
| cfg_clk_inv | input | 1 | 1 moves output updates to the rising edge of ts_clk |
| in_data | input | 8 | Upstream packet byte |
| in_valid | input | 1 | Upstream byte is present |
| in_sop | input | 1 | Upstream byte is the first byte of a packet |
| in_uncor | input | 1 | Packet could not be corrected (sampled with the first byte) |
| in_ready | output | 1 | Formatter accepts the upstream byte this cycle |
| ts_clk | output | 1 | Generated output clock, half the system rate |
| ts_data | output | 8 | Output byte, or the serial bit on bit 0 |
| ts_valid | output | 1 | Output carries a packet byte or bit |
| ts_sync | output | 1 | Output carries the first byte of a packet |
| ts_err | output | 1 | Current packet is flagged uncorrectable |

## Verification
The main path is driven with uninterrupted packets, with packets that have idle gaps placed inside them, and with a short packet cut off by a new start marker. These patterns separate correct byte counting from counters that run on during stalls or fail to restart. Bytes without a start marker, both before the first packet and after a full one, show whether framing comes only from the marker. Alternating the uncorrectable qualifier between the first and the later bytes of a packet shows that the flag is latched once per packet. The same traffic is repeated in serial mode and with the inverted clock edge, which exposes wrong bit order, a stretched or missing start pulse, and updates on the wrong edge.

// File: rtl/ts_out_pkg.sv
package ts_out_pkg;

  typedef enum logic [1:0] {
    TSF_ACT_HOLD,
    TSF_ACT_LOAD,
    TSF_ACT_SHIFT,
    TSF_ACT_GAP
  } tsf_act_e;

  function automatic int unsigned tsf_next_index(input int unsigned idx, input logic restart);
    return restart ? 0 : idx + 1;
  endfunction

  function automatic logic tsf_is_final(input int unsigned idx, input int unsigned len);
    return idx == len - 1;
  endfunction

endpackage

// File: rtl/ts_out_clkgen.sv
module ts_out_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_clk_inv,
  output logic launch,
  output logic ts_clk
);

  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  // outputs update at the end of a cycle with phase_q high
  assign launch = phase_q;
  assign ts_clk = phase_q ^ cfg_clk_inv;

endmodule

// File: rtl/ts_out_pktctl.sv
module ts_out_pktctl
  import ts_out_pkg::*;
#(
  parameter int unsigned PKT_LEN = 188,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sop,
  input  logic             uncor,
  output logic             emit,
  output logic             emit_first,
  output logic             emit_err,
  output logic             gap_err,
  output logic             in_pkt,
  output logic [CNT_W-1:0] byte_idx
);

  logic             in_pkt_q;
  logic             err_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] idx_n;

  assign emit       = take && (sop || in_pkt_q);
  assign emit_first = take && sop;
  assign emit_err   = sop ? uncor : err_q;
  assign gap_err    = in_pkt_q && err_q;
  assign idx_n      = CNT_W'(tsf_next_index(32'(idx_q), sop));
  assign in_pkt     = in_pkt_q;
  assign byte_idx   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      err_q    <= 1'b0;
      idx_q    <= '0;
    end else if (take && sop) begin
      idx_q    <= '0;
      in_pkt_q <= !tsf_is_final(32'd0, PKT_LEN);
      err_q    <= uncor;
    end else if (take && in_pkt_q) begin
      idx_q <= idx_n;
      if (tsf_is_final(32'(idx_n), PKT_LEN)) in_pkt_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ts_out_lane.sv
module ts_out_lane
  import ts_out_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              cfg_serial,
  input  logic              emit,
  input  logic              emit_first,
  input  logic              emit_err,
  input  logic              gap_err,
  input  logic [DATA_W-1:0] emit_data,
  output logic              slot_free,
  output logic [DATA_W-1:0] ts_data,
  output logic              ts_valid,
  output logic              ts_sync,
  output logic              ts_err
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] serial_word(input logic b);
    return {{(DATA_W-1){1'b0}}, b};
  endfunction

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] sh_q;
  logic [BIT_W-1:0]  left_q;
  logic              valid_q;
  logic              sync_q;
  logic              err_q;
  tsf_act_e          act;

  assign slot_free = (left_q == '0);

  always_comb begin
    if (!launch)              act = TSF_ACT_HOLD;
    else if (emit)            act = TSF_ACT_LOAD;
    else if (!slot_free)      act = TSF_ACT_SHIFT;
    else                      act = TSF_ACT_GAP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      sh_q    <= '0;
      left_q  <= '0;
      valid_q <= 1'b0;
      sync_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (act)
        TSF_ACT_LOAD: begin
          valid_q <= 1'b1;
          sync_q  <= emit_first;
          err_q   <= emit_err;
          if (cfg_serial) begin
            data_q <= serial_word(emit_data[DATA_W-1]);
            sh_q   <= emit_data << 1;
            left_q <= LAST_BIT;
          end else begin
            data_q <= emit_data;
            sh_q   <= '0;
            left_q <= '0;
          end
        end
        TSF_ACT_SHIFT: begin
          data_q <= serial_word(sh_q[DATA_W-1]);
          sh_q   <= sh_q << 1;
          left_q <= left_q - 1'b1;
        end
        TSF_ACT_GAP: begin
          valid_q <= 1'b0;
          sync_q  <= 1'b0;
          err_q   <= gap_err;
        end
        default: ;
      endcase
    end
  end

  assign ts_data  = data_q;
  assign ts_valid = valid_q;
  assign ts_sync  = sync_q;
  assign ts_err   = err_q;

endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PKT_LEN = 188
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_serial,
  input  logic              cfg_clk_inv,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_uncor,
  output logic              in_ready,
  output logic              ts_clk,
  output logic [DATA_W-1:0] ts_data,
  output logic              ts_valid,
  output logic              ts_sync,
  output logic              ts_err
);

  localparam int unsigned CNT_W = $clog2(PKT_LEN);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic             launch;
  logic             slot_free;
  logic             take;
  logic             emit;
  logic             emit_first;
  logic             emit_err;
  logic             gap_err;
  logic             in_pkt;
  logic [CNT_W-1:0] byte_idx;

  assign in_ready = launch && (!cfg_serial || slot_free);
  assign take     = in_valid && in_ready;

  ts_out_clkgen u_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_clk_inv (cfg_clk_inv),
    .launch      (launch),
    .ts_clk      (ts_clk)
  );

  ts_out_pktctl #(
    .PKT_LEN (PKT_LEN),
    .CNT_W   (CNT_W)
  ) u_pktctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .sop        (in_sop),
    .uncor      (in_uncor),
    .emit       (emit),
    .emit_first (emit_first),
    .emit_err   (emit_err),
    .gap_err    (gap_err),
    .in_pkt     (in_pkt),
    .byte_idx   (byte_idx)
  );

  ts_out_lane #(
    .DATA_W (DATA_W),
    .BIT_W  (BIT_W)
  ) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .cfg_serial (cfg_serial),
    .emit       (emit),
    .emit_first (emit_first),
    .emit_err   (emit_err),
    .gap_err    (gap_err),
    .emit_data  (in_data),
    .slot_free  (slot_free),
    .ts_data    (ts_data),
    .ts_valid   (ts_valid),
    .ts_sync    (ts_sync),
    .ts_err     (ts_err)
  );

endmodule

// File: rtl/ts_out_fmt_chk.sv
module ts_out_fmt_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PKT_LEN = 188,
  parameter int unsigned CNT_W   = $clog2(PKT_LEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_serial,
  input logic              launch,
  input logic              slot_free,
  input logic              emit,
  input logic              in_pkt,
  input logic [CNT_W-1:0]  byte_idx,
  input logic              in_ready,
  input logic [DATA_W-1:0] ts_data,
  input logic              ts_valid,
  input logic              ts_sync,
  input logic              ts_err
);

  assert_sync_implies_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ts_sync |-> ts_valid);

  assert_serial_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_serial && ts_valid) |-> (ts_data[DATA_W-1:1] == '0));

  assert_hold_between_updates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable({ts_data, ts_valid, ts_sync, ts_err}));

  assert_ready_only_before_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> launch);

  assert_index_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_idx < CNT_W'(PKT_LEN));

  assert_err_clears_after_packet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !emit && !in_pkt && slot_free) |=> !ts_err);

  assert_stall_keeps_position_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && !emit) |=> $stable(byte_idx));

endmodule

bind ts_out_fmt ts_out_fmt_chk #(
  .DATA_W  (DATA_W),
  .PKT_LEN (PKT_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_serial (cfg_serial),
  .launch     (launch),
  .slot_free  (slot_free),
  .emit       (emit),
  .in_pkt     (in_pkt),
  .byte_idx   (byte_idx),
  .in_ready   (in_ready),
  .ts_data    (ts_data),
  .ts_valid   (ts_valid),
  .ts_sync    (ts_sync),
  .ts_err     (ts_err)
);

// File: tb/ts_out_fmt_test.sv
module ts_out_fmt_test;

  localparam int CLK_PERIOD = 10;
  localparam int PKT_LEN    = 188;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_serial = 1'b0;
  logic       cfg_clk_inv = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_sop = 1'b0;
  logic       in_uncor = 1'b0;
  logic       in_ready;
  logic       ts_clk;
  logic [7:0] ts_data;
  logic       ts_valid;
  logic       ts_sync;
  logic       ts_err;

  int n_chk = 0;
  int n_bad = 0;

  // entry: [10] last of packet, [9] err, [8] sync, [7:0] data
  logic [10:0] exp_q[$];

  logic        have_prev = 1'b0;
  logic        prev_lvl;
  logic [10:0] prev_out;
  logic        after_last = 1'b1;
  logic        last_err = 1'b0;

  ts_out_fmt uut (
    .clk (clk), .rst_n (rst_n), .cfg_serial (cfg_serial), .cfg_clk_inv (cfg_clk_inv),
    .in_data (in_data), .in_valid (in_valid), .in_sop (in_sop), .in_uncor (in_uncor),
    .in_ready (in_ready), .ts_clk (ts_clk), .ts_data (ts_data), .ts_valid (ts_valid),
    .ts_sync (ts_sync), .ts_err (ts_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: samples 2 time units after each rising system clock edge
  task automatic monitor_step();
    logic [10:0] cur;
    logic [10:0] e;
    cur = {ts_err, ts_sync, ts_valid, ts_data};
    if (have_prev) begin
      chk((ts_clk ^ cfg_clk_inv) != prev_lvl, "R2 R8 output clock toggles", ts_clk, ~ts_clk);
      if (cur != prev_out)
        chk(ts_clk == cfg_clk_inv, "R2 update on selected edge", ts_clk, cfg_clk_inv);
    end
    have_prev = 1'b1;
    prev_lvl  = ts_clk ^ cfg_clk_inv;
    prev_out  = cur;
    if (in_ready)
      chk(ts_clk == !cfg_clk_inv, "R11 ready only before update", ts_clk, !cfg_clk_inv);
    if (ts_clk == !cfg_clk_inv) begin
      if (ts_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected valid output", {24'h0, ts_data}, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(ts_data == e[7:0], cfg_serial ? "R4 serial bit" : "R3 parallel byte", ts_data, e[7:0]);
          chk(ts_sync == e[8], "R5 sync pulse", ts_sync, e[8]);
          chk(ts_err == e[9], "R7 packet error flag", ts_err, e[9]);
          after_last = e[10];
          last_err   = e[9];
        end
      end else begin
        chk(ts_sync == 1'b0, "R6 no sync without valid", ts_sync, 1'b0);
        chk(ts_err == (after_last ? 1'b0 : last_err), "R7 error flag in gap",
            ts_err, after_last ? 1'b0 : last_err);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) monitor_step();
    end
  end

  // driver: called at a falling clock edge, returns at a falling clock edge
  task automatic drive_byte(input logic [7:0] b, input logic sop, input logic unc);
    in_data  = b;
    in_sop   = sop;
    in_uncor = unc;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b, input logic first, input logic last, input logic err);
    if (cfg_serial) begin
      for (int k = 7; k >= 0; k--)
        exp_q.push_back({last && (k == 0), err, first, 7'h00, b[k]});
    end else begin
      exp_q.push_back({last, err, first, b});
    end
  endtask

  task automatic send_pkt(input int nbytes, input logic [7:0] seed, input logic uerr,
                          input logic unc_rest, input int stall_at, input int stall_len);
    logic [7:0] b;
    for (int i = 0; i < nbytes; i++) begin
      if (i == stall_at) begin
        in_valid = 1'b0;
        repeat (stall_len) @(negedge clk);
      end
      b = (i == 0) ? 8'h47 : 8'(seed + i * 7);
      push_byte(b, i == 0, i == PKT_LEN - 1, uerr);
      drive_byte(b, i == 0, (i == 0) ? uerr : unc_rest);
    end
  endtask

  task automatic send_junk(input int n);
    for (int i = 0; i < n; i++) drive_byte(8'(8'hA5 + i), 1'b0, 1'b1);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(ts_data == 8'h00, "R1 reset data", ts_data, 0);
    chk(ts_valid == 1'b0, "R1 reset valid", ts_valid, 0);
    chk(ts_sync == 1'b0, "R1 reset sync", ts_sync, 0);
    chk(ts_err == 1'b0, "R1 reset err", ts_err, 0);
    chk(ts_clk == 1'b0, "R1 reset clock", ts_clk, 0);
    chk(in_ready == 1'b0, "R1 reset ready", in_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: nothing before the first start marker
    send_junk(4);
    // R3 R7: clean packet, uncor raised on later bytes only (ignored)
    send_pkt(PKT_LEN, 8'h10, 1'b0, 1'b1, -1, 0);
    // R7 R8: flagged packet with a stall; flag taken only from first byte
    send_pkt(PKT_LEN, 8'h33, 1'b1, 1'b0, 60, 9);
    // R9: after a full packet, unmarked bytes are dropped
    send_junk(3);
    // R10: cut-off packet followed by a full one
    send_pkt(50, 8'h5A, 1'b1, 1'b1, -1, 0);
    send_pkt(PKT_LEN, 8'h81, 1'b0, 1'b0, 120, 4);
    send_junk(3);
    drain();

    // R4: serial mode
    cfg_serial = 1'b1;
    @(negedge clk);
    send_pkt(PKT_LEN, 8'hC3, 1'b1, 1'b0, -1, 0);
    send_pkt(PKT_LEN, 8'h0F, 1'b0, 1'b1, 17, 13);
    send_junk(2);
    drain();

    // R2: inverted output clock edge
    cfg_serial  = 1'b0;
    cfg_clk_inv = 1'b1;
    @(negedge clk);
    send_pkt(PKT_LEN, 8'h6E, 1'b1, 1'b0, 90, 5);
    send_junk(2);
    drain();

    chk(exp_q.size() == 0, "R8 R9 R10 all expected output seen", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog: actual=150000 cycles expected=completion");
    summary();
    $finish;
  end

endmodule